// File: doc/BRIEF.md
# Multi-Width Signed Integer ALU with Status Flags

This block is a registered arithmetic unit for two's-complement integers. Each accepted strobe carries two operands, an operation code and a width selector. The width selector picks one of three operand sizes: the base width, twice the base width, or four times it. That gives 16, 32 or 64 bits with the default base of 16. One clock later the unit presents a result, a result-write qualifier and a valid pulse. It also presents three status indicators that persist between operations: an overflow flag, a three-way condition code and a carry flag.

The supported operations are add, subtract, negate, compare, multiply, divide and load/test. Each operation follows its own rule for which flags it touches. Overflow-capable operations always write the overflow flag, either setting or clearing it. Compare and load/test never touch the overflow flag. Multiply and divide always clear the carry flag. Subtract reports "no borrow" in the carry flag. A zero divisor counts as an overflow. When an operation overflows while the trap enable input is high, the unit raises a single-cycle trap request next to the valid pulse.

Top module: `int_alu_flags`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. In cycles without `in_valid`, `result`, `v_flag`, `cc` and `k_flag` hold their values.
- R2: The operand width w depends on `width_sel`: 0 gives BASE_W, 1 gives 2·BASE_W, and 2 or 3 give 4·BASE_W. Operand bits at or above w are ignored, and result bits at or above w are zero.
- R3: Add (op 0) writes the sum truncated to w bits and sets `k_flag` to the carry out of bit w−1. It sets `v_flag` to 1 on signed overflow and clears it otherwise.
- R4: Subtract (op 1) writes A−B truncated to w bits and sets `k_flag` to 1 exactly when A ≥ B as unsigned w-bit values. It sets `v_flag` on signed overflow and clears it otherwise.
- R5: Negate (op 2) writes the inverse of A plus one, truncated to w bits. `v_flag` is 1 only for the most negative w-bit value. `k_flag` is 1 only when A is zero, treating the operation as 0−A.
- R6: Compare (op 3) drops `res_write` low and leaves `result` unchanged. It sets `cc` from the signed ordering of A against B and sets `k_flag` to unsigned A ≥ B. It leaves `v_flag` unchanged.
- R7: Multiply (op 4) clears `k_flag` and writes the low w bits of the signed product. It sets `v_flag` when the full product does not fit in w signed bits and clears it otherwise. The result value is unspecified on overflow.
- R8: Divide (op 5) clears `k_flag` and writes the quotient truncated toward zero. It sets `v_flag` when the divisor is zero or when the most negative value is divided by −1, and clears it otherwise. The result value is unspecified on overflow.
- R9: Load/test (op 6 or op 7) writes A (low w bits) as the result and sets `cc` from it. It leaves `v_flag` and `k_flag` unchanged.
- R10: `cc` encodes negative as 2'b01, zero as 2'b10 and positive as 2'b11. For result-writing operations, `cc` is taken from the written, truncated w-bit result.
- R11: `trap_req` is high for one cycle, together with `out_valid`, exactly when the operation overflowed and `trap_en` was high with the strobe.
- R12: After reset, all outputs are zero. This includes `cc` (2'b00, meaning no code yet).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (see R3 to R9) |
| width_sel | input | 2 | Operand width selector |
| opa | input | 4·BASE_W | Operand A |
| opb | input | 4·BASE_W | Operand B |
| trap_en | input | 1 | Overflow trap enable |
| out_valid | output | 1 | Result/flag update pulse |
| res_write | output | 1 | Result was written by this operation |
| result | output | 4·BASE_W | Registered result |
| v_flag | output | 1 | Overflow indicator |
| cc | output | 2 | Condition code |
| k_flag | output | 1 | Carry / no-borrow indicator |
| trap_req | output | 1 | Overflow trap request pulse |

## Verification
The bench goes after the boundary pairs where the flags are easiest to get wrong. Adding or subtracting around the most positive and most negative values checks the overflow flag. A unit that took overflow from the carry would mark unsigned wraps as signed overflow. Subtract and compare with equal operands, and with operands whose top bits differ, check the no-borrow polarity of the carry flag. Getting that polarity backwards flips every comparison the software builds on it. Negating zero and negating the most negative value, dividing by zero, and dividing the most negative value by −1 catch designs that only look at the quotient's width. Load/test and compare operations that follow an overflow check that those operations leave the overflow flag alone. Operand bits placed above the selected width catch a unit that forgets to mask or sign-extend.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_NEG  = 3'd2,
    OP_CMP  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_LDT  = 3'd6,
    OP_LDT2 = 3'd7
  } op_e;

  localparam logic [1:0] CC_NONE = 2'b00;
  localparam logic [1:0] CC_NEG  = 2'b01;
  localparam logic [1:0] CC_ZERO = 2'b10;
  localparam logic [1:0] CC_POS  = 2'b11;

  // Three-way code from a zero test and a sign test.
  function automatic logic [1:0] cc_code(input logic is_zero, input logic is_neg);
    if (is_zero)     return CC_ZERO;
    else if (is_neg) return CC_NEG;
    else             return CC_POS;
  endfunction

endpackage

// File: rtl/alu_width_fmt.sv
`timescale 1ns/1ps
module alu_width_fmt #(
  parameter int BASE_W = 16,
  localparam int MAXW = 4 * BASE_W,
  localparam int WB = $clog2(MAXW) + 1
) (
  input  logic [1:0]      width_sel,
  input  logic [MAXW-1:0] opa,
  input  logic [MAXW-1:0] opb,
  output logic [WB-1:0]   w,
  output logic [MAXW-1:0] mask,
  output logic [MAXW-1:0] a_z,
  output logic [MAXW-1:0] b_z,
  output logic [MAXW-1:0] a_s,
  output logic [MAXW-1:0] b_s
);

  always_comb begin
    case (width_sel)
      2'd0:    w = WB'(BASE_W);
      2'd1:    w = WB'(2 * BASE_W);
      default: w = WB'(MAXW);
    endcase
    mask = {MAXW{1'b1}} >> (WB'(MAXW) - w);
    a_z  = opa & mask;
    b_z  = opb & mask;
    a_s  = opa[w - WB'(1)] ? (a_z | ~mask) : a_z;
    b_s  = opb[w - WB'(1)] ? (b_z | ~mask) : b_z;
  end

endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int MAXW = 64,
  localparam int WB = $clog2(MAXW) + 1
) (
  input  logic [MAXW-1:0] a_z,
  input  logic [MAXW-1:0] b_z,
  input  logic [MAXW-1:0] mask,
  input  logic [WB-1:0]   w,
  input  logic            sub,
  input  logic            neg,
  output logic [MAXW-1:0] res,
  output logic            ovf,
  output logic            carry
);

  logic [MAXW:0]   lhs, rhs, total;
  logic [MAXW-1:0] rhs_src;
  logic            c_into_top;

  always_comb begin
    lhs     = neg ? '0 : {1'b0, a_z};
    rhs_src = neg ? a_z : b_z;
    rhs     = sub ? {1'b0, ~rhs_src & mask} : {1'b0, rhs_src};
    total   = lhs + rhs + {{MAXW{1'b0}}, sub};
    res     = total[MAXW-1:0] & mask;
    carry   = total[w];
    // Signed overflow: carry into the top bit differs from carry out of it.
    c_into_top = total[w - WB'(1)] ^ lhs[w - WB'(1)] ^ rhs[w - WB'(1)];
    ovf        = c_into_top ^ total[w];
  end

endmodule

// File: rtl/alu_muldiv.sv
`timescale 1ns/1ps
module alu_muldiv #(
  parameter int MAXW = 64
) (
  input  logic [MAXW-1:0] a_s,
  input  logic [MAXW-1:0] b_s,
  input  logic [MAXW-1:0] mask,
  input  logic            is_div,
  output logic [MAXW-1:0] res,
  output logic            ovf,
  output logic            div_zero
);

  logic signed [2*MAXW-1:0] prod, prod_back;
  logic [MAXW-1:0]          prod_lo, b_safe, quo, min_s;
  logic                     mul_ovf, min_by_m1;

  always_comb begin
    prod      = $signed({{MAXW{a_s[MAXW-1]}}, a_s}) * $signed({{MAXW{b_s[MAXW-1]}}, b_s});
    prod_lo   = prod[MAXW-1:0] & mask;
    // Sign-extend the truncated product back and compare with the full one.
    prod_back = (|(prod_lo & ~(mask >> 1))) ? {{MAXW{1'b1}}, prod_lo | ~mask}
                                            : {{MAXW{1'b0}}, prod_lo};
    mul_ovf   = (prod != prod_back);

    div_zero  = (b_s == '0);
    min_s     = ~(mask >> 1);
    min_by_m1 = (a_s == min_s) && (b_s == {MAXW{1'b1}});
    b_safe    = div_zero ? {{(MAXW-1){1'b0}}, 1'b1} : b_s;
    quo       = (div_zero || min_by_m1) ? '0 : MAXW'($signed(a_s) / $signed(b_safe));

    res = is_div ? (quo & mask) : prod_lo;
    ovf = is_div ? (div_zero || min_by_m1) : mul_ovf;
  end

endmodule

// File: rtl/int_alu_flags.sv
`timescale 1ns/1ps
module int_alu_flags
  import alu_pkg::*;
#(
  parameter int BASE_W = 16,
  localparam int MAXW = 4 * BASE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [1:0]      width_sel,
  input  logic [MAXW-1:0] opa,
  input  logic [MAXW-1:0] opb,
  input  logic            trap_en,
  output logic            out_valid,
  output logic            res_write,
  output logic [MAXW-1:0] result,
  output logic            v_flag,
  output logic [1:0]      cc,
  output logic            k_flag,
  output logic            trap_req
);

  localparam int WB = $clog2(MAXW) + 1;

  logic [WB-1:0]   w;
  logic [MAXW-1:0] mask, a_z, b_z, a_s, b_s;
  logic [MAXW-1:0] as_res, md_res;
  logic            as_ovf, as_carry, md_ovf, md_dz;
  op_e             opc;
  logic            as_sub, as_neg, is_div;

  // Named internal events, used by the checker.
  logic            ovf_capable, ovf_raw, ovf_event, dz_event;

  logic [MAXW-1:0] nx_res;
  logic            nx_wr, nx_v, nx_k;
  logic [1:0]      nx_cc, cmp_cc;

  assign opc    = op_e'(op);
  assign as_neg = (opc == OP_NEG);
  assign as_sub = (opc == OP_SUB) || (opc == OP_CMP) || as_neg;
  assign is_div = (opc == OP_DIV);

  alu_width_fmt #(.BASE_W(BASE_W)) u_fmt (
    .width_sel(width_sel), .opa(opa), .opb(opb),
    .w(w), .mask(mask), .a_z(a_z), .b_z(b_z), .a_s(a_s), .b_s(b_s)
  );

  alu_addsub #(.MAXW(MAXW)) u_addsub (
    .a_z(a_z), .b_z(b_z), .mask(mask), .w(w), .sub(as_sub), .neg(as_neg),
    .res(as_res), .ovf(as_ovf), .carry(as_carry)
  );

  alu_muldiv #(.MAXW(MAXW)) u_muldiv (
    .a_s(a_s), .b_s(b_s), .mask(mask), .is_div(is_div),
    .res(md_res), .ovf(md_ovf), .div_zero(md_dz)
  );

  assign cmp_cc = cc_code(a_s == b_s, $signed(a_s) < $signed(b_s));

  always_comb begin
    nx_res      = result;
    nx_wr       = 1'b1;
    nx_k        = k_flag;
    ovf_capable = 1'b0;
    ovf_raw     = 1'b0;
    case (opc)
      OP_ADD, OP_SUB, OP_NEG: begin
        nx_res      = as_res;
        nx_k        = as_carry;
        ovf_capable = 1'b1;
        ovf_raw     = as_ovf;
      end
      OP_CMP: begin
        nx_wr = 1'b0;
        nx_k  = as_carry;
      end
      OP_MUL, OP_DIV: begin
        nx_res      = md_res;
        nx_k        = 1'b0;
        ovf_capable = 1'b1;
        ovf_raw     = md_ovf;
      end
      default: nx_res = a_z;
    endcase
    nx_v  = ovf_capable ? ovf_raw : v_flag;
    nx_cc = (opc == OP_CMP) ? cmp_cc : cc_code(nx_res == '0, nx_res[w - WB'(1)]);
  end

  assign ovf_event = in_valid && ovf_capable && ovf_raw;
  assign dz_event  = in_valid && is_div && md_dz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_write <= 1'b0;
      result    <= '0;
      v_flag    <= 1'b0;
      cc        <= CC_NONE;
      k_flag    <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      res_write <= in_valid && nx_wr;
      trap_req  <= ovf_event && trap_en;
      if (in_valid) begin
        result <= nx_res;
        v_flag <= nx_v;
        cc     <= nx_cc;
        k_flag <= nx_k;
      end
    end
  end

endmodule

// File: rtl/int_alu_flags_checker.sv
`timescale 1ns/1ps
module int_alu_flags_checker
  import alu_pkg::*;
#(
  parameter int MAXW = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      op,
  input logic [MAXW-1:0] opb,
  input logic            out_valid,
  input logic            res_write,
  input logic            v_flag,
  input logic [1:0]      cc,
  input logic            k_flag,
  input logic            trap_req,
  input logic            ovf_event,
  input logic            dz_event
);

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(v_flag) && $stable(cc) && $stable(k_flag)));

  assert_ovf_sets_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> v_flag);

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMP) |=> (!res_write && v_flag == $past(v_flag)));

  assert_k_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_MUL || op == OP_DIV)) |=> !k_flag);

  assert_div_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_DIV && opb == '0) |=> v_flag);

  assert_dz_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dz_event |=> (v_flag && out_valid));

  assert_cc_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cc != CC_NONE));

  assert_trap_qual_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (v_flag && out_valid));

  assert_trap_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> !trap_req);

endmodule

bind int_alu_flags int_alu_flags_checker #(.MAXW(MAXW)) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opb(opb),
  .out_valid(out_valid), .res_write(res_write), .v_flag(v_flag), .cc(cc),
  .k_flag(k_flag), .trap_req(trap_req), .ovf_event(ovf_event), .dz_event(dz_event)
);

// File: tb/int_alu_flags_test.sv
`timescale 1ns/1ps
module int_alu_flags_test;

  localparam int BW = 4;
  localparam int MW = 4 * BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [2:0]    op;
  logic [1:0]    width_sel;
  logic [MW-1:0] opa, opb;
  logic          trap_en;
  logic          out_valid, res_write, v_flag, k_flag, trap_req;
  logic [MW-1:0] result;
  logic [1:0]    cc;

  always #2.5 clk = ~clk;

  int_alu_flags #(.BASE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .width_sel(width_sel),
    .opa(opa), .opb(opb), .trap_en(trap_en), .out_valid(out_valid),
    .res_write(res_write), .result(result), .v_flag(v_flag), .cc(cc),
    .k_flag(k_flag), .trap_req(trap_req)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  // Model state of the persistent flags and result.
  logic          m_v, m_k;
  logic [1:0]    m_cc;
  logic [MW-1:0] m_res;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint sx(input longint u, input int w);
    return u[w-1] ? (u - (64'sd1 <<< w)) : u;
  endfunction

  function automatic logic [1:0] cc_of(input longint s);
    if (s == 0)     return 2'b10;
    else if (s < 0) return 2'b01;
    else            return 2'b11;
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Issue one operation at a negedge, then check one cycle later.
  task automatic run(input int o, input int ws, input longint a, input longint b, input bit ten);
    int     w;
    longint mask, ua, ub, sa, sb, full, lo, hi, exp_res;
    bit     ov, ov_cap, wr, res_def;
    logic [1:0] exp_cc;
    logic   exp_k;
    string  t;
    w    = BW << ((ws > 2) ? 2 : ws);
    mask = (64'sd1 <<< w) - 1;
    ua = a & mask; ub = b & mask;
    sa = sx(ua, w); sb = sx(ub, w);
    lo = -(64'sd1 <<< (w - 1)); hi = (64'sd1 <<< (w - 1)) - 1;
    t  = tag_of(o);

    op        = 3'(o);
    width_sel = 2'(ws);
    opa       = MW'((a & mask) | (64'hB6D9 ^ (a << 3)) & ~mask);
    opb       = MW'((b & mask) | (64'h5A3C ^ (b << 5)) & ~mask);
    trap_en   = ten;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;

    ov = 0; ov_cap = 1; wr = 1; res_def = 1; full = 0; exp_k = m_k; exp_res = 0;
    case (o)
      0: begin full = sa + sb; exp_k = ((ua + ub) >> w) & 1; end
      1: begin full = sa - sb; exp_k = (ua >= ub); end
      2: begin full = -sa;     exp_k = (ua == 0); end
      3: begin ov_cap = 0; wr = 0; exp_k = (ua >= ub); end
      4: begin full = sa * sb; exp_k = 0; end
      5: begin
           exp_k = 0;
           if (sb == 0) begin ov = 1; full = 0; end
           else full = sa / sb;
         end
      default: begin ov_cap = 0; full = sa; end
    endcase
    if (ov_cap && !(o == 5 && sb == 0)) ov = (full < lo) || (full > hi);
    exp_res = full & mask;
    if ((o == 4 || o == 5) && ov) res_def = 0;

    if (wr) begin
      if (res_def) exp_cc = cc_of(sx(exp_res, w));
      else         exp_cc = cc_of(sx(longint'(result) & mask, w));
    end else begin
      exp_cc = (sa < sb) ? 2'b01 : ((sa == sb) ? 2'b10 : 2'b11);
    end
    if (ov_cap) m_v = ov;
    m_k = exp_k; m_cc = exp_cc;
    if (wr && res_def) m_res = MW'(exp_res);

    check(out_valid == 1'b1, "R1", "out_valid", longint'(out_valid), 1);
    check(res_write == wr, t, "res_write", longint'(res_write), longint'(wr));
    if (wr && res_def)
      check(result == MW'(exp_res), t, "result", longint'(result), exp_res);
    else if (!wr)
      check(result == m_res, "R6", "result held", longint'(result), longint'(m_res));
    check((longint'(result) & ~mask) == 0, "R2", "upper result bits", longint'(result), 0);
    check(v_flag == m_v, t, "v_flag", longint'(v_flag), longint'(m_v));
    check(k_flag == m_k, t, "k_flag", longint'(k_flag), longint'(m_k));
    check(cc == m_cc, "R10", "cc", longint'(cc), longint'(m_cc));
    check(trap_req == (ov_cap && ov && ten), "R11", "trap_req",
          longint'(trap_req), longint'(ov_cap && ov && ten));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  longint vals8  [16] = '{0, 1, 2, 3, 'h7f, 'h80, 'h81, 'hff, 'hfe, 'h40, 'h55, 'haa, 'h10, 'hc0, 'h7e, 'h0f};
  longint vals16 [12] = '{0, 1, 2, 'h7fff, 'h8000, 'h8001, 'hffff, 'hfffe, 'h00ff, 'h0100, 'h1234, 'hc000};

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; width_sel = '0;
    opa = '0; opb = '0; trap_en = 1'b0;
    m_v = 0; m_k = 0; m_cc = 2'b00; m_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(out_valid == 0 && res_write == 0 && trap_req == 0, "R12", "reset strobes",
          longint'({out_valid, res_write, trap_req}), 0);
    check(result == '0, "R12", "reset result", longint'(result), 0);
    check(v_flag == 0 && k_flag == 0 && cc == 2'b00, "R12", "reset flags",
          longint'({v_flag, k_flag, cc}), 0);

    // Exhaustive sweep at the base width.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int o = 0; o < 8; o++)
          run(o, 0, a, b, bit'((a ^ b ^ o) & 1));

    // R1: idle cycles change nothing.
    @(negedge clk); @(negedge clk);
    check(out_valid == 0, "R1", "idle out_valid", longint'(out_valid), 0);
    check(v_flag == m_v && k_flag == m_k && cc == m_cc && result == m_res, "R1", "idle hold",
          longint'({v_flag, k_flag, cc}), longint'({m_v, m_k, m_cc}));

    // Double width: every A against corner B values.
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 16; j++)
        for (int o = 0; o < 8; o++)
          run(o, 1, a, vals8[j], bit'((a + j + o) & 1));

    // Full width (selector 2 and 3): corner pairs.
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int o = 0; o < 8; o++)
          run(o, 2 + ((i + j) & 1), vals16[i], vals16[j], bit'((i ^ o) & 1));

    @(negedge clk);
    finish_run();
  end

endmodule